// File: doc/BRIEF.md
# Shared-Cache Way-Quota Victim Selector

This block picks the way to evict from one set of a shared set-associative cache when a core misses. Each line carries the id of the core that filled it. Those ids are held here in a small per-set table. The caller supplies the index of the set, the valid bit of each way and a recency age for each way. It also supplies the id of the core that missed and the number of ways that core may hold in a set.

The selector counts how many valid lines of the set the requester already owns. If that count is below the quota, the requester may grow, so it takes the oldest line that belongs to some other core. If the count has reached the quota, it must recycle one of its own lines, so it takes its own oldest line. An empty way always wins over both choices. When the group that would be preferred has no members, the oldest line of the whole set is taken.

The choice is combinational. On a cycle with the fill strobe raised, the chosen way's owner field is rewritten with the requester's id at the clock edge. The updated owners of the addressed set can be read back on an output port.

Top module: `wq_victim_sel`

## Requirements
- R1: After reset every owner field of every set reads 0 on `set_owners`. The owner of way w sits at bits [w*2 +: 2].
- R2: If any way of the set is invalid, the victim is the lowest-indexed invalid way and `victim_kind` is 0.
- R3: `own_count` equals the number of valid ways whose owner field equals `req_id`.
- R4: With all ways valid and `own_count < quota`, if some valid way has an owner other than `req_id`, the victim is the one among those with the largest age, and `victim_kind` is 1. Age w sits at `line_age[w*3 +: 3]`; a larger age means less recently used, and a tie goes to the lower index.
- R5: With all ways valid and `own_count >= quota`, if the requester owns at least one way, the victim is its owned way with the largest age (same tie rule), and `victim_kind` is 2.
- R6: With all ways valid, if the group that R4 or R5 would draw from is empty, the victim is the way with the largest age in the set (same tie rule), and `victim_kind` is 3.
- R7: At a rising edge with `fill_en` high, the owner field of the chosen way in the addressed set becomes `req_id`. All other ways and sets keep their owners.
- R8: At a rising edge with `fill_en` low, no owner field changes.
- R9: `victim_way`, `victim_kind` and `own_count` follow a change of the inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the owner table |
| set_idx | input | 4 | Index of the set being looked up |
| line_valid | input | 8 | Valid bit of each way |
| line_age | input | 24 | Recency age per way, 3 bits each, larger = older |
| req_id | input | 2 | Id of the core that missed |
| quota | input | 4 | Ways the requester may hold in a set |
| fill_en | input | 1 | Write requester id into the chosen way at this edge |
| victim_way | output | 3 | Way to evict |
| victim_kind | output | 2 | 0 invalid, 1 other core's LRU, 2 own LRU, 3 set-wide fallback |
| own_count | output | 4 | Valid ways owned by the requester |
| set_owners | output | 16 | Owner ids of the addressed set, 2 bits per way |

## Verification
A wrong owner field written by a fill shows up on `set_owners` on the very next cycle that addresses that set. It also skews `own_count` at once. That skew can flip the choice between growing and recycling, so a damaged entry moves `victim_way` on the next miss that reaches it. A fault in the quota comparison or in the age ordering is combinational, so it shows in the same cycle its inputs arrive. For that reason every output is compared with the behavioural model on every vector, including the owners after every edge.

// File: rtl/wq_pkg.sv
package wq_pkg;

  typedef enum logic [1:0] {
    VK_INVALID  = 2'd0,
    VK_OTHER    = 2'd1,
    VK_OWN      = 2'd2,
    VK_FALLBACK = 2'd3
  } victim_kind_e;

endpackage

// File: rtl/wq_owner_table.sv
module wq_owner_table #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int CID_W = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ROW_W = WAYS * CID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [ROW_W-1:0] rd_owners,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [CID_W-1:0] wr_id
);

  logic [ROW_W-1:0] rows [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rows[s] <= '0;
    end else if (wr_en) begin
      rows[rd_set][wr_way*CID_W +: CID_W] <= wr_id;
    end
  end

  assign rd_owners = rows[rd_set];

endmodule

// File: rtl/wq_occupancy.sv
module wq_occupancy #(
  parameter int WAYS  = 8,
  parameter int CID_W = 2,
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*CID_W-1:0] owners,
  input  logic [CID_W-1:0]      req_id,
  output logic [WAYS-1:0]       own_mask,
  output logic [WAYS-1:0]       other_mask,
  output logic [CNT_W-1:0]      own_cnt
);

  function automatic logic [CNT_W-1:0] ones(input logic [WAYS-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < WAYS; i++) if (m[i]) c = c + 1'b1;
    return c;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic mine;
    assign mine          = owners[w*CID_W +: CID_W] == req_id;
    assign own_mask[w]   = valid[w] & mine;
    assign other_mask[w] = valid[w] & ~mine;
  end

  assign own_cnt = ones(own_mask);

endmodule

// File: rtl/wq_lru_pick.sv
module wq_lru_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       mask,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic                  any,
  output logic [WAY_W-1:0]      way
);

  logic [AGE_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    way  = '0;
    best = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (mask[i] && (!any || ages[i*AGE_W +: AGE_W] > best)) begin
        any  = 1'b1;
        way  = WAY_W'(i);
        best = ages[i*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/wq_victim_sel.sv
module wq_victim_sel #(
  parameter int SETS  = 16,
  parameter int WAYS  = 8,
  parameter int CORES = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W,
  localparam int CID_W = $clog2(CORES),
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       set_idx,
  input  logic [WAYS-1:0]        line_valid,
  input  logic [WAYS*AGE_W-1:0]  line_age,
  input  logic [CID_W-1:0]       req_id,
  input  logic [CNT_W-1:0]       quota,
  input  logic                   fill_en,
  output logic [WAY_W-1:0]       victim_way,
  output logic [1:0]             victim_kind,
  output logic [CNT_W-1:0]       own_count,
  output logic [WAYS*CID_W-1:0]  set_owners
);
  import wq_pkg::*;

  localparam int GROUPS = 3;  // 0 other, 1 own, 2 whole set

  logic [WAYS*CID_W-1:0] owners_rd;
  logic [WAYS-1:0]       own_mask, other_mask;
  logic [WAYS-1:0]       grp_mask [GROUPS];
  logic                  grp_any  [GROUPS];
  logic [WAY_W-1:0]      grp_way  [GROUPS];

  // named events for the checks
  logic                  has_invalid;
  logic                  may_grow;
  logic [CID_W-1:0]      victim_owner;
  victim_kind_e          kind;

  function automatic logic [WAY_W-1:0] first_clear(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    logic             hit;
    r   = '0;
    hit = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!v[i] && !hit) begin
        r   = WAY_W'(i);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  wq_owner_table #(.SETS(SETS), .WAYS(WAYS), .CID_W(CID_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (set_idx),
    .rd_owners(owners_rd),
    .wr_en    (fill_en),
    .wr_way   (victim_way),
    .wr_id    (req_id)
  );

  wq_occupancy #(.WAYS(WAYS), .CID_W(CID_W)) u_occ (
    .valid     (line_valid),
    .owners    (owners_rd),
    .req_id    (req_id),
    .own_mask  (own_mask),
    .other_mask(other_mask),
    .own_cnt   (own_count)
  );

  assign grp_mask[0] = other_mask;
  assign grp_mask[1] = own_mask;
  assign grp_mask[2] = {WAYS{1'b1}};

  for (genvar g = 0; g < GROUPS; g++) begin : g_pick
    wq_lru_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
      .mask(grp_mask[g]),
      .ages(line_age),
      .any (grp_any[g]),
      .way (grp_way[g])
    );
  end

  assign has_invalid = ~&line_valid;
  assign may_grow    = own_count < quota;

  always_comb begin
    if (has_invalid) begin
      kind       = VK_INVALID;
      victim_way = first_clear(line_valid);
    end else if (may_grow && grp_any[0]) begin
      kind       = VK_OTHER;
      victim_way = grp_way[0];
    end else if (!may_grow && grp_any[1]) begin
      kind       = VK_OWN;
      victim_way = grp_way[1];
    end else begin
      kind       = VK_FALLBACK;
      victim_way = grp_way[2];
    end
  end

  assign victim_kind  = kind;
  assign set_owners   = owners_rd;
  assign victim_owner = owners_rd[victim_way*CID_W +: CID_W];

  // ---------------- checks ----------------
  logic             chk_fill_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  logic [CID_W-1:0] chk_id_q;
  logic [CID_W-1:0] chk_owner_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_fill_q <= 1'b0;
      chk_set_q  <= '0;
      chk_way_q  <= '0;
      chk_id_q   <= '0;
    end else begin
      chk_fill_q <= fill_en;
      chk_set_q  <= set_idx;
      chk_way_q  <= victim_way;
      chk_id_q   <= req_id;
    end
  end

  assign chk_owner_now = owners_rd[chk_way_q*CID_W +: CID_W];

  assert_invalid_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    has_invalid |-> (kind == VK_INVALID) && !line_valid[victim_way]);

  assert_other_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == VK_OTHER) |-> line_valid[victim_way] && (victim_owner != req_id) && may_grow);

  assert_own_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == VK_OWN) |-> (victim_owner == req_id) && !may_grow);

  assert_fallback_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == VK_FALLBACK) |-> &line_valid);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    own_count <= CNT_W'(WAYS));

  assert_fill_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fill_q && chk_set_q == set_idx) |-> chk_owner_now == chk_id_q);

endmodule

// File: tb/wq_victim_sel_tb.sv
module wq_victim_sel_tb_top;
  localparam int SETS = 16, WAYS = 8, CORES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  set_idx = '0;
  logic [7:0]  line_valid = '0;
  logic [23:0] line_age = '0;
  logic [1:0]  req_id = '0;
  logic [3:0]  quota = '0;
  logic        fill_en = 1'b0;
  logic [2:0]  victim_way;
  logic [1:0]  victim_kind;
  logic [3:0]  own_count;
  logic [15:0] set_owners;

  int vectors = 0;
  int fails = 0;
  int own_m [SETS][WAYS];
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  wq_victim_sel #(.SETS(SETS), .WAYS(WAYS), .CORES(CORES)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .line_valid(line_valid),
    .line_age(line_age), .req_id(req_id), .quota(quota), .fill_en(fill_en),
    .victim_way(victim_way), .victim_kind(victim_kind), .own_count(own_count),
    .set_owners(set_owners)
  );

  task automatic cmp(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int age_of(input int w);
    return int'(line_age[w*3 +: 3]);
  endfunction

  // reference: returns oldest way among flagged ways, -1 if none
  function automatic int oldest(input bit flags [WAYS]);
    int pick = -1;
    foreach (flags[w])
      if (flags[w] && (pick < 0 || age_of(w) > age_of(pick))) pick = w;
    return pick;
  endfunction

  task automatic check_owners(input string req);
    for (int w = 0; w < WAYS; w++)
      cmp(req, int'(set_owners[w*2 +: 2]), own_m[set_idx][w]);
  endtask

  // drive one vector at the falling edge, check, then let the edge apply
  task automatic apply(input int s, input logic [7:0] v, input int rq,
                       input int q, input bit f);
    int ages [WAYS];
    int cnt, exp_way, exp_kind, pick;
    bit mine [WAYS], other [WAYS], all [WAYS];
    foreach (ages[w]) ages[w] = w;
    for (int w = WAYS - 1; w > 0; w--) begin
      int j = int'($urandom_range(w, 0));
      int t = ages[w]; ages[w] = ages[j]; ages[j] = t;
    end
    @(negedge clk);
    set_idx = 4'(s); line_valid = v; req_id = 2'(rq); quota = 4'(q); fill_en = f;
    for (int w = 0; w < WAYS; w++) line_age[w*3 +: 3] = 3'(ages[w]);
    #1;
    cnt = 0;
    for (int w = 0; w < WAYS; w++) begin
      mine[w]  = v[w] && own_m[s][w] == rq;
      other[w] = v[w] && own_m[s][w] != rq;
      all[w]   = 1'b1;
      if (mine[w]) cnt++;
    end
    exp_way = -1;
    for (int w = WAYS - 1; w >= 0; w--) if (!v[w]) exp_way = w;
    if (exp_way >= 0) exp_kind = 0;
    else begin
      pick = (cnt < q) ? oldest(other) : oldest(mine);
      exp_kind = (cnt < q) ? 1 : 2;
      if (pick < 0) begin pick = oldest(all); exp_kind = 3; end
      exp_way = pick;
    end
    check_owners("R7/R8 owners");
    cmp("R3 own_count", int'(own_count), cnt);
    case (exp_kind)
      0: cmp("R2 kind", int'(victim_kind), 0);
      1: cmp("R4 kind", int'(victim_kind), 1);
      2: cmp("R5 kind", int'(victim_kind), 2);
      default: cmp("R6 kind", int'(victim_kind), 3);
    endcase
    cmp("R9 victim_way", int'(victim_way), exp_way);
    @(posedge clk);
    if (f) own_m[s][exp_way] = rq;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    foreach (own_m[s, w]) own_m[s][w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: every set reads all-zero owners after reset
    for (int s = 0; s < SETS; s++) begin
      @(negedge clk); set_idx = 4'(s); #1;
      check_owners("R1 reset owners");
    end
    // R2/R7: fill set 5 way by way with core 1, lowest invalid first
    for (int k = 0; k < WAYS; k++) apply(5, 8'((1 << k) - 1), 1, 4, 1);
    // R5: quota reached, own LRU
    apply(5, 8'hFF, 1, 8, 0);
    // R6: other group empty while growth allowed
    apply(5, 8'hFF, 1, 9, 0);
    // R6: own group empty with zero quota
    apply(5, 8'hFF, 2, 0, 0);
    // R4: core 2 may grow into core 1's lines; fill a few
    apply(5, 8'hFF, 2, 3, 1);
    apply(5, 8'hFF, 2, 3, 1);
    apply(5, 8'hFF, 2, 3, 1);
    // R5: core 2 now at quota 3
    apply(5, 8'hFF, 2, 3, 1);
    // R8: no fill, owners of set 5 must stay
    apply(5, 8'hFF, 3, 2, 0);
    apply(5, 8'hFF, 3, 2, 0);
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] v;
      v = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'hFF;
      apply(int'($urandom_range(SETS - 1, 0)), v, int'($urandom_range(3, 0)),
            int'($urandom_range(WAYS + 1, 0)), bit'($urandom_range(1, 0)));
    end
    @(negedge clk); fill_en = 1'b0; #1;
    check_owners("R8 final owners");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule